// File: doc/BRIEF.md
# UART Host Command and Control Interface

This block is the microcontroller-facing control logic of a serial receiver/transmitter. A host reaches it over an 8-bit parallel bus with an active-low select, separate active-low read and write strobes, and a command/data select line. Bus writes go either to the transmit FIFO (data) or to a small command register bank (command). Bus reads return either the head of the receive FIFO (data) or a status byte (command). The serial shifters, baud timing and FIFO storage live outside the block and connect through push/pop pulses and level flags.

The command registers drive the modem handshake output, two general-purpose port outputs and the interrupt polarity. They also gate the transmitter, which may run only while its enable bit is set and clear-to-send is held low. One interrupt line merges receive-full, transmit-empty and block-reception-done. A data write into a full transmit FIFO and a data read from an empty receive FIFO are each remembered in a sticky status bit until the next status read. All strobes are sampled on the block clock, and each access acts once, on the first clock edge at which its strobe is seen low.

Top module: `uart_host_ctrl`

## Requirements
- R1: While `cs_n` is high, strobes are ignored: no FIFO push or pop, no command register change, and `dout_en` stays low.
- R2: `dout_en` is high exactly while `cs_n` and `rd_n` are low and `wr_n` is high; `dout` holds the read result from the clock after the read strobe is first sampled low.
- R3: A data write (`cmd_sel` low) with `tx_full` low gives exactly one `tx_push` pulse in the clock after the strobe is first sampled, with `tx_wdata` equal to the bus byte.
- R4: A data read returns `rx_data` and gives one `rx_pop` pulse when `rx_empty` is low; when `rx_empty` is high it returns 0x00, gives no pop and sets the underrun bit.
- R5: A status read returns bit0 = receive data available (not `rx_empty`), bit1 = transmit room (not `tx_full`), bit2 = `rx_full`, bit3 = `tx_empty`, bit4 = `blk_done`, bit5 = transmit overrun, bit6 = receive underrun, bit7 = clear-to-send asserted (not `cts_n`).
- R6: A command write carries the register index in bits 7:5 and the payload in bits 4:0; index 4 is transmit control, index 6 is port control, and writes to any other index change no output.
- R7: `irq` follows receive-full OR transmit-empty OR block-done one clock later, active high when port-control bit 2 is 1 and active low when it is 0.
- R8: `port_a` equals port-control bit 0; `port_b` equals port-control bit 3 when port-control bit 1 is 0, and follows `pkt_done` when it is 1.
- R9: `tx_allow` is high only when transmit-control bit 0 is 1 and `cts_n` is low; `rts_n` is the inverse of transmit-control bit 3.
- R10: A data write while `tx_full` is high is dropped (no `tx_push`) and sets the overrun bit.
- R11: A status read returns the sticky overrun and underrun bits and then clears both.
- R12: Reset clears every command register and both sticky bits: `port_a`, `port_b` low, `rts_n` high, `tx_allow` low, `irq` high (active-low and idle).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| cmd_sel | input | 1 | High: command/status, low: transfer data |
| din | input | 8 | Bus byte from host |
| dout | output | 8 | Bus byte to host |
| dout_en | output | 1 | Bus drive enable for the read byte |
| tx_wdata | output | 8 | Byte pushed into the transmit FIFO |
| tx_push | output | 1 | One-clock push pulse to the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_pop | output | 1 | One-clock pop pulse to the receive FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| blk_done | input | 1 | Block reception complete flag |
| pkt_done | input | 1 | Packet transmission complete flag |
| cts_n | input | 1 | Active-low clear-to-send |
| tx_allow | output | 1 | Transmitter may send |
| rts_n | output | 1 | Active-low request-to-send |
| port_a | output | 1 | General-purpose output A |
| port_b | output | 1 | General-purpose output B or packet-done indicator |
| irq | output | 1 | Interrupt request, programmable polarity |

## Verification
On every cycle the assertions check that a deselected bus causes no FIFO traffic, that no push follows a full flag and no pop follows an empty flag, that pushes never come back to back, that the transmitter is never allowed while clear-to-send is inactive, and that the interrupt equals the polarity-adjusted merge of its sources one clock earlier. The status byte layout, the clear-on-read of the sticky bits, the command index decode and the ignored indices, the port-B source switch, and the full clearing of the register bank by a mid-run reset can only be shown by the bench's bus scenarios, which compare every pushed and read byte against a scoreboard.

// File: rtl/uhc_pkg.sv
// Package: shared types and field positions for the UART host control block.
// Assumes an 8-bit status byte; bit positions are fixed by the host protocol.
package uhc_pkg;

    // One-clock access pulses produced by the bus decoder.
    typedef struct packed {
        logic wr_data;
        logic wr_cmd;
        logic rd_data;
        logic rd_stat;
    } uhc_acc_t;

    // Status byte bit positions.
    localparam int ST_RX_AVAIL = 0;
    localparam int ST_TX_ROOM  = 1;
    localparam int ST_RX_FULL  = 2;
    localparam int ST_TX_EMPTY = 3;
    localparam int ST_BLK_DONE = 4;
    localparam int ST_OVR      = 5;
    localparam int ST_UND      = 6;
    localparam int ST_CTS      = 7;

    // Transmit-control register payload bits.
    localparam int TC_TXEN = 0;
    localparam int TC_RTS  = 3;

    // Port-control register payload bits.
    localparam int PC_A_LVL  = 0;
    localparam int PC_B_PKT  = 1;
    localparam int PC_IRQ_HI = 2;
    localparam int PC_B_LVL  = 3;

    // Payload bits actually consumed by the bank.
    localparam int PAY_USED = 4;

endpackage

// File: rtl/uhc_bus_decode.sv
// Module: bus decoder. Samples the select and strobes on clk and emits one
// access pulse on the first clock a strobe is seen active while selected.
// Assumes strobes stay low for at least one clock; a write strobe masks a
// simultaneous read strobe.
module uhc_bus_decode
    import uhc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n,
    input  logic     rd_n,
    input  logic     wr_n,
    input  logic     cmd_sel,
    output uhc_acc_t acc,
    output logic     drive_en
);

    localparam int NSTB = 2;   // index 0: write, index 1: read

    logic [NSTB-1:0] act;
    logic [NSTB-1:0] act_q;
    logic [NSTB-1:0] start;

    // Active levels of each strobe qualified by select.
    always_comb begin
        act[0] = ~cs_n & ~wr_n;
        act[1] = ~cs_n & ~rd_n & wr_n;
    end

    // Per-strobe history and leading-edge detection.
    for (genvar g = 0; g < NSTB; g++) begin : g_stb
        // Remember last sampled activity of this strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) act_q[g] <= 1'b0;
            else        act_q[g] <= act[g];
        end
        assign start[g] = act[g] & ~act_q[g];
    end

    // Split leading edges by command/data select.
    always_comb begin
        acc.wr_data = start[0] & ~cmd_sel;
        acc.wr_cmd  = start[0] &  cmd_sel;
        acc.rd_data = start[1] & ~cmd_sel;
        acc.rd_stat = start[1] &  cmd_sel;
    end

    assign drive_en = act[1];

endmodule

// File: rtl/uhc_ctrl_regs.sv
// Module: command register bank. A command byte carries the index in its top
// IDX_W bits and the payload below. Only the transmit-control and port-control
// indices hold state; other indices are accepted and leave outputs unchanged.
// Assumes the caller supplies only the payload bits that are consumed.
module uhc_ctrl_regs
    import uhc_pkg::*;
#(
    parameter int IDX_W    = 3,
    parameter int TX_IDX   = 4,
    parameter int PORT_IDX = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W-1:0]    idx,
    input  logic [PAY_USED-1:0] pay,
    output logic                tx_en,
    output logic                rts_req,
    output logic                a_lvl,
    output logic                b_pkt,
    output logic                b_lvl,
    output logic                irq_hi
);

    localparam int NBANK = 2;   // 0: transmit control, 1: port control
    localparam logic [IDX_W-1:0] TX_SEL   = IDX_W'(TX_IDX);
    localparam logic [IDX_W-1:0] PORT_SEL = IDX_W'(PORT_IDX);

    logic [NBANK-1:0]               hit;
    logic [NBANK-1:0][PAY_USED-1:0] bank_q;

    // Index match per stored register.
    always_comb begin
        hit[0] = we & (idx == TX_SEL);
        hit[1] = we & (idx == PORT_SEL);
    end

    // One payload register per stored index.
    for (genvar g = 0; g < NBANK; g++) begin : g_reg
        // Load payload on a matching command write; master reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)      bank_q[g] <= '0;
            else if (hit[g]) bank_q[g] <= pay;
        end
    end

    // Field extraction.
    always_comb begin
        tx_en   = bank_q[0][TC_TXEN];
        rts_req = bank_q[0][TC_RTS];
        a_lvl   = bank_q[1][PC_A_LVL];
        b_pkt   = bank_q[1][PC_B_PKT];
        b_lvl   = bank_q[1][PC_B_LVL];
        irq_hi  = bank_q[1][PC_IRQ_HI];
    end

    // Transmit-control bits 1 and 2 are stored but drive nothing here.
    logic unused_tc;
    assign unused_tc = ^bank_q[0][2:1];

endmodule

// File: rtl/uhc_irq.sv
// Module: interrupt output stage. Registers the merged request with the
// selected polarity so the pin never glitches. Reset leaves it at the idle
// level of the reset polarity (active low, so high).
module uhc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic active_high,
    output logic irq
);

    // Apply polarity and register.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b1;
        else        irq <= active_high ? raw : ~raw;
    end

endmodule

// File: rtl/uart_host_ctrl.sv
// Module: UART host command and control interface (top). Decodes host bus
// accesses, routes data to/from the FIFO ports, keeps sticky error bits,
// drives handshake and port outputs and the interrupt.
// Assumes synchronous host strobes and FIFO flags valid on each clock.
module uart_host_ctrl
    import uhc_pkg::*;
#(
    parameter int DW       = 8,
    parameter int IDX_W    = 3,
    parameter int TX_IDX   = 4,
    parameter int PORT_IDX = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          cmd_sel,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic [DW-1:0] tx_wdata,
    output logic          tx_push,
    input  logic          tx_full,
    input  logic          tx_empty,
    input  logic [DW-1:0] rx_data,
    output logic          rx_pop,
    input  logic          rx_empty,
    input  logic          rx_full,
    input  logic          blk_done,
    input  logic          pkt_done,
    input  logic          cts_n,
    output logic          tx_allow,
    output logic          rts_n,
    output logic          port_a,
    output logic          port_b,
    output logic          irq
);

    localparam int IDX_LSB = DW - IDX_W;

    uhc_acc_t      acc;
    logic          tx_en, rts_req, a_lvl, b_pkt, b_lvl;
    logic          irq_pol;
    logic          irq_raw;
    logic          ovr_q, und_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] status_w;
    logic          push_ok, read_empty;

    uhc_bus_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .cmd_sel  (cmd_sel),
        .acc      (acc),
        .drive_en (dout_en)
    );

    uhc_ctrl_regs #(
        .IDX_W    (IDX_W),
        .TX_IDX   (TX_IDX),
        .PORT_IDX (PORT_IDX)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (acc.wr_cmd),
        .idx     (din[DW-1:IDX_LSB]),
        .pay     (din[PAY_USED-1:0]),
        .tx_en   (tx_en),
        .rts_req (rts_req),
        .a_lvl   (a_lvl),
        .b_pkt   (b_pkt),
        .b_lvl   (b_lvl),
        .irq_hi  (irq_pol)
    );

    assign irq_raw = rx_full | tx_empty | blk_done;

    uhc_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw         (irq_raw),
        .active_high (irq_pol),
        .irq         (irq)
    );

    // Status byte assembly from live flags and sticky bits.
    always_comb begin
        status_w              = '0;
        status_w[ST_RX_AVAIL] = ~rx_empty;
        status_w[ST_TX_ROOM]  = ~tx_full;
        status_w[ST_RX_FULL]  = rx_full;
        status_w[ST_TX_EMPTY] = tx_empty;
        status_w[ST_BLK_DONE] = blk_done;
        status_w[ST_OVR]      = ovr_q;
        status_w[ST_UND]      = und_q;
        status_w[ST_CTS]      = ~cts_n;
    end

    assign push_ok    = acc.wr_data & ~tx_full;
    assign read_empty = acc.rd_data & rx_empty;

    // Transmit path: register the byte and a one-clock push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_push  <= 1'b0;
            tx_wdata <= '0;
        end else begin
            tx_push <= push_ok;
            if (push_ok) tx_wdata <= din;
        end
    end

    // Read path: capture FIFO head, zero or status; pop only when not empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rx_pop  <= 1'b0;
        end else begin
            rx_pop <= acc.rd_data & ~rx_empty;
            if (acc.rd_data)      rdata_q <= rx_empty ? '0 : rx_data;
            else if (acc.rd_stat) rdata_q <= status_w;
        end
    end

    // Sticky error bits: set on dropped access, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            und_q <= 1'b0;
        end else if (acc.rd_stat) begin
            ovr_q <= 1'b0;
            und_q <= 1'b0;
        end else begin
            if (acc.wr_data & tx_full) ovr_q <= 1'b1;
            if (read_empty)            und_q <= 1'b1;
        end
    end

    // Pin outputs derived from the command registers.
    always_comb begin
        dout     = rdata_q;
        tx_allow = tx_en & ~cts_n;
        rts_n    = ~rts_req;
        port_a   = a_lvl;
        port_b   = b_pkt ? pkt_done : b_lvl;
    end

endmodule

// File: rtl/uhc_host_ctrl_chk.sv
// Module: assertion checker for uart_host_ctrl, attached with bind.
module uhc_host_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic cts_n,
    input logic tx_full,
    input logic rx_empty,
    input logic tx_push,
    input logic rx_pop,
    input logic tx_allow,
    input logic irq,
    input logic irq_raw,
    input logic irq_pol
);

    // R1: a clock with the bus deselected causes no FIFO traffic next clock.
    p_desel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (!tx_push && !rx_pop));

    // R3: one push per write strobe, never back to back.
    p_single_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> !tx_push);

    // R4: no pop follows an empty receive FIFO.
    p_no_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !$past(rx_empty));

    // R10: no push follows a full transmit FIFO.
    p_no_full_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !$past(tx_full));

    // R9: the transmitter is never allowed without clear-to-send.
    p_cts_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_allow |-> !cts_n);

    // R7: interrupt equals the polarity-adjusted merge one clock earlier.
    p_irq_pol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == ($past(irq_pol) ? $past(irq_raw) : !$past(irq_raw))));

endmodule

bind uart_host_ctrl uhc_host_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .cts_n    (cts_n),
    .tx_full  (tx_full),
    .rx_empty (rx_empty),
    .tx_push  (tx_push),
    .rx_pop   (rx_pop),
    .tx_allow (tx_allow),
    .irq      (irq),
    .irq_raw  (irq_raw),
    .irq_pol  (irq_pol)
);

// File: tb/tb_uart_host_ctrl.sv
`timescale 1ns/1ps
module tb_uart_host_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs_n, rd_n, wr_n, cmd_sel;
    logic [7:0] din, dout, tx_wdata, rx_data;
    logic       dout_en, tx_push, tx_full, tx_empty, rx_pop, rx_empty, rx_full;
    logic       blk_done, pkt_done, cts_n, tx_allow, rts_n, port_a, port_b, irq;

    int  n_chk = 0;
    int  n_bad = 0;
    int  pop_cnt = 0;
    bit  rd_check = 0;
    bit  done = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rd[$];

    always #4 clk = ~clk;

    uart_host_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .cmd_sel(cmd_sel), .din(din), .dout(dout), .dout_en(dout_en),
        .tx_wdata(tx_wdata), .tx_push(tx_push), .tx_full(tx_full),
        .tx_empty(tx_empty), .rx_data(rx_data), .rx_pop(rx_pop),
        .rx_empty(rx_empty), .rx_full(rx_full), .blk_done(blk_done),
        .pkt_done(pkt_done), .cts_n(cts_n), .tx_allow(tx_allow),
        .rts_n(rts_n), .port_a(port_a), .port_b(port_b), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] stat(input bit o, input bit u);
        return {~cts_n, u, o, blk_done, tx_empty, rx_full, ~tx_full, ~rx_empty};
    endfunction

    function automatic logic [7:0] cmd(input int idx, input logic [4:0] pay);
        return {idx[2:0], pay};
    endfunction

    task automatic bus_wr(input logic sel_n, input logic c, input logic [7:0] v);
        @(negedge clk);
        cs_n = sel_n; cmd_sel = c; din = v; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic bus_rd(input logic c, input logic [7:0] exp);
        exp_rd.push_back(exp);
        @(negedge clk);
        cs_n = 1'b0; cmd_sel = c; rd_n = 1'b0;
        @(posedge clk); #2 rd_check = 1;
        @(posedge clk); #2 rd_check = 0;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
    endtask

    // Scoreboard monitor: compares pushes and read bytes against queues.
    always @(negedge clk) begin
        if (tx_push) begin
            if (exp_tx.size() == 0) chk("R3 unexpected push", 32'(tx_wdata), 32'hFFFF_FFFF);
            else chk("R3 pushed byte", 32'(tx_wdata), 32'(exp_tx.pop_front()));
        end
        if (rd_check) begin
            chk("R2 drive enable", 32'(dout_en), 1);
            if (exp_rd.size() == 0) chk("R2 unexpected read", 32'(dout), 32'hFFFF_FFFF);
            else chk("R2 read byte", 32'(dout), 32'(exp_rd.pop_front()));
        end
        if (rx_pop) pop_cnt++;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int pc;
        rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; cmd_sel = 0; din = 0;
        tx_full = 0; tx_empty = 0; rx_data = 0; rx_empty = 1; rx_full = 0;
        blk_done = 0; pkt_done = 0; cts_n = 1;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 irq", 32'(irq), 1);
        chk("R12 port_a", 32'(port_a), 0);
        chk("R12 port_b", 32'(port_b), 0);
        chk("R12 rts_n", 32'(rts_n), 1);
        chk("R12 tx_allow", 32'(tx_allow), 0);
        chk("R12 dout_en", 32'(dout_en), 0);
        rst_n = 1;
        @(negedge clk);

        // R1: deselected writes and reads are ignored
        bus_wr(1'b1, 1'b0, 8'hA5);
        bus_wr(1'b1, 1'b1, cmd(6, 5'b01001));
        chk("R1 port_a after deselected command", 32'(port_a), 0);
        chk("R1 port_b after deselected command", 32'(port_b), 0);
        @(negedge clk); rd_n = 0;
        @(negedge clk);
        chk("R1 dout_en while deselected", 32'(dout_en), 0);
        rd_n = 1;

        // R3: data writes reach the transmit FIFO
        exp_tx.push_back(8'h3C); bus_wr(1'b0, 1'b0, 8'h3C);
        exp_tx.push_back(8'h81); bus_wr(1'b0, 1'b0, 8'h81);
        @(negedge clk);

        // R9: transmit gating and request-to-send
        bus_wr(1'b0, 1'b1, cmd(4, 5'b01001));
        chk("R9 tx_allow cts inactive", 32'(tx_allow), 0);
        chk("R9 rts_n asserted", 32'(rts_n), 0);
        @(negedge clk); cts_n = 0; #1;
        chk("R9 tx_allow enabled", 32'(tx_allow), 1);
        bus_wr(1'b0, 1'b1, cmd(4, 5'b01000));
        chk("R9 tx_allow disabled bit", 32'(tx_allow), 0);

        // R8: port outputs
        bus_wr(1'b0, 1'b1, cmd(6, 5'b01001));
        chk("R8 port_a level", 32'(port_a), 1);
        chk("R8 port_b level", 32'(port_b), 1);
        bus_wr(1'b0, 1'b1, cmd(6, 5'b00010));
        chk("R8 port_a cleared", 32'(port_a), 0);
        chk("R8 port_b pkt low", 32'(port_b), 0);
        @(negedge clk); pkt_done = 1; #1;
        chk("R8 port_b pkt high", 32'(port_b), 1);

        // R6: other indices leave every output unchanged
        bus_wr(1'b0, 1'b1, cmd(2, 5'b11111));
        bus_wr(1'b0, 1'b1, cmd(5, 5'b11111));
        bus_wr(1'b0, 1'b1, cmd(7, 5'b11111));
        @(negedge clk);
        chk("R6 port_a", 32'(port_a), 0);
        chk("R6 port_b", 32'(port_b), 1);
        chk("R6 rts_n", 32'(rts_n), 0);
        chk("R6 tx_allow", 32'(tx_allow), 0);
        chk("R6 irq polarity kept", 32'(irq), 1);

        // R7: interrupt sources and polarity
        rx_full = 1; @(negedge clk);
        chk("R7 rx_full low-active", 32'(irq), 0);
        rx_full = 0; tx_empty = 1; @(negedge clk);
        chk("R7 tx_empty low-active", 32'(irq), 0);
        tx_empty = 0; blk_done = 1; @(negedge clk);
        chk("R7 blk_done low-active", 32'(irq), 0);
        blk_done = 0; @(negedge clk);
        chk("R7 idle low-active", 32'(irq), 1);
        bus_wr(1'b0, 1'b1, cmd(6, 5'b00100));
        @(negedge clk);
        chk("R7 idle high-active", 32'(irq), 0);
        tx_empty = 1; @(negedge clk);
        chk("R7 tx_empty high-active", 32'(irq), 1);

        // R5: status layout
        rx_empty = 0; rx_full = 1; tx_empty = 1;
        bus_rd(1'b1, stat(0, 0));

        // R10 / R11: overrun sticky and clear-on-read
        tx_full = 1;
        bus_wr(1'b0, 1'b0, 8'h55);
        @(negedge clk);
        bus_rd(1'b1, stat(1, 0));
        bus_rd(1'b1, stat(0, 0));
        tx_full = 0;

        // R4: reads from empty and non-empty receive FIFO
        rx_empty = 1; rx_full = 0;
        pc = pop_cnt;
        bus_rd(1'b0, 8'h00);
        @(negedge clk);
        chk("R4 no pop when empty", 32'(pop_cnt), 32'(pc));
        bus_rd(1'b1, stat(0, 1));
        bus_rd(1'b1, stat(0, 0));
        rx_empty = 0; rx_data = 8'hC3;
        bus_rd(1'b0, 8'hC3);
        @(negedge clk);
        chk("R4 single pop", 32'(pop_cnt), 32'(pc + 1));

        // R11: both sticky bits reported together
        tx_full = 1; bus_wr(1'b0, 1'b0, 8'h11); tx_full = 0;
        rx_empty = 1; bus_rd(1'b0, 8'h00);
        bus_rd(1'b1, stat(1, 1));
        bus_rd(1'b1, stat(0, 0));

        // R12: mid-run reset clears registers and sticky bits
        bus_wr(1'b0, 1'b1, cmd(4, 5'b01001));
        bus_wr(1'b0, 1'b1, cmd(6, 5'b01001));
        tx_full = 1; bus_wr(1'b0, 1'b0, 8'h22); tx_full = 0;
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R12 irq in reset", 32'(irq), 1);
        rst_n = 1;
        @(negedge clk);
        chk("R12 port_a after reset", 32'(port_a), 0);
        chk("R12 port_b after reset", 32'(port_b), 0);
        chk("R12 rts_n after reset", 32'(rts_n), 1);
        chk("R12 tx_allow after reset", 32'(tx_allow), 0);
        bus_rd(1'b1, stat(0, 0));

        repeat (4) @(negedge clk);
        chk("R3 all pushes seen", 32'(exp_tx.size()), 0);
        chk("R2 all reads seen", 32'(exp_rd.size()), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule